// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the vertical sync, horizontal sync and data-enable strobes of a video frame. All three come from one frame-position counter that advances once per pixel clock. Each strobe is placed by an absolute offset from the start of the frame. There is no per-line porch state machine. Vertical sync is a single window. Horizontal sync and data enable are each a train of pulses with a programmed high time, low time and pulse count. Each train begins a programmed number of pixel clocks after the vertical sync rising edge.

Software loads the eleven timing fields through a plain write port while the block is idle. It then raises `enable`. The frame repeats for as long as `enable` stays high. During every active pixel the block also presents the pixel column and the active line index, so a downstream pixel source can use them. Writes that arrive while `enable` is high are discarded, so the timing cannot change during streaming.

Top module: `vsync_timing_gen`

## Requirements
- R1: After reset every timing field is zero and `vs_o`, `hs_o`, `de_o`, `px_x` and `px_y` are zero. With all fields zero the outputs stay zero even when `enable` is high.
- R2: While `enable` is low, a `wr_en` pulse writes `wr_data` into the field selected by `wr_addr`. The field map is: 0 VS offset, 1 VS high, 2 VS low, 3 HS delay, 4 HS high, 5 HS low, 6 HS count, 7 DE delay, 8 DE high, 9 DE low, 10 DE count. Offsets, delays, VS high and VS low are 24 bits wide. The other fields take the low 16 bits of `wr_data`.
- R3: A write presented while `enable` is high changes no field. The frame produced afterwards is identical to the frame produced before the write.
- R4: The first rising clock edge that samples `enable` high starts the frame at position 0. Position advances by one per clock. Position wraps to 0 after VS offset + VS high + VS low pixel clocks.
- R5: `vs_o` is high exactly at the frame positions p where VS offset ≤ p < VS offset + VS high.
- R6: Let S = VS offset + HS delay and P = HS high + HS low. `hs_o` is high at position p when p ≥ S, k = (p−S)/P is less than HS count, and (p−S) mod P < HS high. Once the count is used up, `hs_o` stays low until the next frame start.
- R7: `de_o` follows the rule of R6, using the DE delay, DE high, DE low and DE count fields.
- R8: While `de_o` is high, `px_x` equals (p−S) mod P of the DE train and `px_y` equals the DE pulse index k. Both are zero while `de_o` is low.
- R9: At every frame start both trains are cut short and restart. A train whose start position lies beyond the frame length never fires.
- R10: One clock after `enable` is sampled low, all strobes are low. The next enable begins again at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frame generation; blocks field writes |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 4 | Field select (map in R2) |
| wr_data | input | 24 | Field write value |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| px_x | output | 16 | Pixel column within the active line |
| px_y | output | 16 | Active line index |

## Verification
Some properties are checked on every cycle. The timing fields stay frozen while enabled. Frame position stays below the frame length and steps by one or wraps. The strobes go quiet after enable drops. The horizontal pulse count never exceeds its programmed value. The pixel column starts at zero and steps by one within a line. The exact edge positions of every strobe, truncation at the frame boundary, merged pulses when a low time is zero, and the effect of discarded writes can only be shown by the bench scenarios. These scenarios compare each output on every cycle of several whole frames against an arithmetic model of the frame position.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int unsigned TG_LW = 24;
  localparam int unsigned TG_SW = 16;
  localparam int unsigned TG_AW = 4;

  typedef enum logic [TG_AW-1:0] {
    FLD_VS_OFS  = 4'd0,
    FLD_VS_HI   = 4'd1,
    FLD_VS_LO   = 4'd2,
    FLD_HS_DLY  = 4'd3,
    FLD_HS_HI   = 4'd4,
    FLD_HS_LO   = 4'd5,
    FLD_HS_CNT  = 4'd6,
    FLD_DE_DLY  = 4'd7,
    FLD_DE_HI   = 4'd8,
    FLD_DE_LO   = 4'd9,
    FLD_DE_CNT  = 4'd10
  } fld_addr_e;
endpackage

// File: rtl/tg_fields.sv
module tg_fields #(
  parameter int unsigned LW = tg_pkg::TG_LW,
  parameter int unsigned SW = tg_pkg::TG_SW,
  parameter int unsigned AW = tg_pkg::TG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_data,
  output logic [LW-1:0] vs_ofs,
  output logic [LW-1:0] vs_hi,
  output logic [LW-1:0] vs_lo,
  output logic [LW-1:0] hs_dly,
  output logic [SW-1:0] hs_hi,
  output logic [SW-1:0] hs_lo,
  output logic [SW-1:0] hs_cnt,
  output logic [LW-1:0] de_dly,
  output logic [SW-1:0] de_hi,
  output logic [SW-1:0] de_lo,
  output logic [SW-1:0] de_cnt
);
  import tg_pkg::*;

  logic [LW-1:0] vs_ofs_d, vs_hi_d, vs_lo_d, hs_dly_d, de_dly_d;
  logic [SW-1:0] hs_hi_d, hs_lo_d, hs_cnt_d, de_hi_d, de_lo_d, de_cnt_d;
  logic [SW-1:0] short_val;

  assign short_val = wr_data[SW-1:0];

  always_comb begin
    vs_ofs_d = vs_ofs;
    vs_hi_d  = vs_hi;
    vs_lo_d  = vs_lo;
    hs_dly_d = hs_dly;
    hs_hi_d  = hs_hi;
    hs_lo_d  = hs_lo;
    hs_cnt_d = hs_cnt;
    de_dly_d = de_dly;
    de_hi_d  = de_hi;
    de_lo_d  = de_lo;
    de_cnt_d = de_cnt;
    if (wr_ok) begin
      case (wr_addr)
        FLD_VS_OFS: vs_ofs_d = wr_data;
        FLD_VS_HI:  vs_hi_d  = wr_data;
        FLD_VS_LO:  vs_lo_d  = wr_data;
        FLD_HS_DLY: hs_dly_d = wr_data;
        FLD_HS_HI:  hs_hi_d  = short_val;
        FLD_HS_LO:  hs_lo_d  = short_val;
        FLD_HS_CNT: hs_cnt_d = short_val;
        FLD_DE_DLY: de_dly_d = wr_data;
        FLD_DE_HI:  de_hi_d  = short_val;
        FLD_DE_LO:  de_lo_d  = short_val;
        FLD_DE_CNT: de_cnt_d = short_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_ofs <= '0;
      vs_hi  <= '0;
      vs_lo  <= '0;
      hs_dly <= '0;
      hs_hi  <= '0;
      hs_lo  <= '0;
      hs_cnt <= '0;
      de_dly <= '0;
      de_hi  <= '0;
      de_lo  <= '0;
      de_cnt <= '0;
    end else if (wr_ok) begin
      vs_ofs <= vs_ofs_d;
      vs_hi  <= vs_hi_d;
      vs_lo  <= vs_lo_d;
      hs_dly <= hs_dly_d;
      hs_hi  <= hs_hi_d;
      hs_lo  <= hs_lo_d;
      hs_cnt <= hs_cnt_d;
      de_dly <= de_dly_d;
      de_hi  <= de_hi_d;
      de_lo  <= de_lo_d;
      de_cnt <= de_cnt_d;
    end
  end
endmodule

// File: rtl/tg_position.sv
module tg_position #(
  parameter int unsigned PW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] frame_len,
  output logic [PW-1:0] pos_d,
  output logic [PW-1:0] pos_q,
  output logic          run_q
);
  logic [PW-1:0] pos_inc;

  assign pos_inc = pos_q + PW'(1);

  always_comb begin
    if (!enable || !run_q)        pos_d = '0;
    else if (pos_inc >= frame_len) pos_d = '0;
    else                           pos_d = pos_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      run_q <= enable;
    end
  end
endmodule

// File: rtl/tg_train.sv
module tg_train #(
  parameter int unsigned SW = tg_pkg::TG_SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fire,
  input  logic [SW-1:0] hi_len,
  input  logic [SW-1:0] lo_len,
  input  logic [SW-1:0] count,
  output logic          out,
  output logic [SW-1:0] phase,
  output logic [SW-1:0] index
);
  logic          busy_q, busy_d, hi_q, hi_d;
  logic [SW-1:0] ph_q, ph_d, idx_q, idx_d;
  logic          last_pulse, hi_end, lo_end, fire_ok;

  assign last_pulse = (idx_q == count - SW'(1));
  assign hi_end     = (ph_q == hi_len - SW'(1));
  assign lo_end     = (ph_q == lo_len - SW'(1));
  assign fire_ok    = fire && (count != '0) && (hi_len != '0);

  always_comb begin
    busy_d = busy_q;
    hi_d   = hi_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    if (busy_q) begin
      if (hi_q) begin
        if (!hi_end) begin
          ph_d = ph_q + SW'(1);
        end else if (lo_len != '0) begin
          hi_d = 1'b0;
          ph_d = '0;
        end else if (last_pulse) begin
          busy_d = 1'b0;
        end else begin
          ph_d  = '0;
          idx_d = idx_q + SW'(1);
        end
      end else begin
        if (!lo_end) begin
          ph_d = ph_q + SW'(1);
        end else if (last_pulse) begin
          busy_d = 1'b0;
        end else begin
          hi_d  = 1'b1;
          ph_d  = '0;
          idx_d = idx_q + SW'(1);
        end
      end
    end
    if (clear) busy_d = 1'b0;
    if (fire_ok) begin
      busy_d = 1'b1;
      hi_d   = 1'b1;
      ph_d   = '0;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      ph_q   <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      hi_q   <= hi_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
    end
  end

  assign out   = busy_q & hi_q;
  assign phase = ph_q;
  assign index = idx_q;
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen #(
  parameter int unsigned LW = tg_pkg::TG_LW,
  parameter int unsigned SW = tg_pkg::TG_SW,
  parameter int unsigned AW = tg_pkg::TG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_data,
  output logic          vs_o,
  output logic          hs_o,
  output logic          de_o,
  output logic [SW-1:0] px_x,
  output logic [SW-1:0] px_y
);
  localparam int unsigned PW = LW + 2;
  localparam int unsigned NTRAIN = 2;

  logic [LW-1:0] cfg_vs_ofs, cfg_vs_hi, cfg_vs_lo, cfg_hs_dly, cfg_de_dly;
  logic [SW-1:0] cfg_hs_hi, cfg_hs_lo, cfg_hs_cnt;
  logic [SW-1:0] cfg_de_hi, cfg_de_lo, cfg_de_cnt;
  logic [PW-1:0] frame_len, vs_end, pos_d, pos_q;
  logic          run_q, frame_clear, vs_d, vs_q;

  tg_fields #(.LW(LW), .SW(SW), .AW(AW)) i_fields (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_en & ~enable),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .vs_ofs(cfg_vs_ofs), .vs_hi(cfg_vs_hi), .vs_lo(cfg_vs_lo),
    .hs_dly(cfg_hs_dly), .hs_hi(cfg_hs_hi), .hs_lo(cfg_hs_lo),
    .hs_cnt(cfg_hs_cnt), .de_dly(cfg_de_dly), .de_hi(cfg_de_hi),
    .de_lo(cfg_de_lo), .de_cnt(cfg_de_cnt)
  );

  assign frame_len = PW'(cfg_vs_ofs) + PW'(cfg_vs_hi) + PW'(cfg_vs_lo);
  assign vs_end    = PW'(cfg_vs_ofs) + PW'(cfg_vs_hi);

  tg_position #(.PW(PW)) i_position (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_len(frame_len),
    .pos_d(pos_d), .pos_q(pos_q), .run_q(run_q)
  );

  assign frame_clear = (pos_d == '0);
  assign vs_d = enable && (pos_d >= PW'(cfg_vs_ofs)) && (pos_d < vs_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vs_d;
  end

  logic [LW-1:0] tr_dly [NTRAIN];
  logic [SW-1:0] tr_hi  [NTRAIN];
  logic [SW-1:0] tr_lo  [NTRAIN];
  logic [SW-1:0] tr_cnt [NTRAIN];
  logic          tr_out [NTRAIN];
  logic [SW-1:0] tr_ph  [NTRAIN];
  logic [SW-1:0] tr_idx [NTRAIN];

  assign tr_dly[0] = cfg_hs_dly;
  assign tr_hi[0]  = cfg_hs_hi;
  assign tr_lo[0]  = cfg_hs_lo;
  assign tr_cnt[0] = cfg_hs_cnt;
  assign tr_dly[1] = cfg_de_dly;
  assign tr_hi[1]  = cfg_de_hi;
  assign tr_lo[1]  = cfg_de_lo;
  assign tr_cnt[1] = cfg_de_cnt;

  for (genvar g = 0; g < NTRAIN; g++) begin : g_train
    logic [PW-1:0] start_pos;
    logic          fire;
    assign start_pos = PW'(cfg_vs_ofs) + PW'(tr_dly[g]);
    assign fire      = enable && (pos_d == start_pos);
    tg_train #(.SW(SW)) i_train (
      .clk(clk), .rst_n(rst_n), .clear(frame_clear), .fire(fire),
      .hi_len(tr_hi[g]), .lo_len(tr_lo[g]), .count(tr_cnt[g]),
      .out(tr_out[g]), .phase(tr_ph[g]), .index(tr_idx[g])
    );
  end

  assign vs_o = vs_q;
  assign hs_o = tr_out[0];
  assign de_o = tr_out[1];
  assign px_x = tr_out[1] ? tr_ph[1]  : '0;
  assign px_y = tr_out[1] ? tr_idx[1] : '0;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int unsigned LW = tg_pkg::TG_LW,
  parameter int unsigned SW = tg_pkg::TG_SW,
  parameter int unsigned PW = LW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          vs_o,
  input logic          hs_o,
  input logic          de_o,
  input logic [SW-1:0] px_x,
  input logic [PW-1:0] pos_q,
  input logic          run_q,
  input logic [PW-1:0] frame_len,
  input logic [LW-1:0] cfg_vs_ofs,
  input logic [LW-1:0] cfg_vs_hi,
  input logic [SW-1:0] cfg_hs_hi,
  input logic [SW-1:0] cfg_hs_cnt,
  input logic [SW-1:0] cfg_de_hi
);
  logic          hs_prev;
  logic [SW:0]   hs_rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev  <= 1'b0;
      hs_rises <= '0;
    end else begin
      hs_prev <= hs_o;
      if (!run_q || pos_q == '0)
        hs_rises <= (SW+1)'(hs_o && !hs_prev);
      else
        hs_rises <= hs_rises + (SW+1)'(hs_o && !hs_prev);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(vs_o || hs_o || de_o)); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(cfg_vs_ofs) && $stable(cfg_vs_hi) && $stable(cfg_hs_hi)
               && $stable(cfg_hs_cnt) && $stable(cfg_de_hi))); // R3

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && frame_len != '0) |-> pos_q < frame_len); // R4

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && enable && frame_len != '0)
      |-> (pos_q == '0 || pos_q == $past(pos_q) + PW'(1))); // R4

  AST_HS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable) |-> hs_rises <= (SW+1)'(cfg_hs_cnt)); // R6

  AST_PX_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> px_x == '0); // R8

  AST_PX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && $past(de_o) && px_x != '0) |-> px_x == $past(px_x) + SW'(1)); // R8
endmodule

bind vsync_timing_gen tg_checker #(.LW(LW), .SW(SW), .PW(PW)) i_tg_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .vs_o(vs_o), .hs_o(hs_o),
  .de_o(de_o), .px_x(px_x), .pos_q(pos_q), .run_q(run_q),
  .frame_len(frame_len), .cfg_vs_ofs(cfg_vs_ofs), .cfg_vs_hi(cfg_vs_hi),
  .cfg_hs_hi(cfg_hs_hi), .cfg_hs_cnt(cfg_hs_cnt), .cfg_de_hi(cfg_de_hi)
);

// File: tb/test_vsync_timing_gen.sv
module test_vsync_timing_gen;
  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [23:0] wr_data;
  logic        vs_o, hs_o, de_o;
  logic [15:0] px_x, px_y;

  int n_cmp = 0;
  int n_bad = 0;
  int c_vo, c_vh, c_vl, c_hd, c_hh, c_hl, c_hc, c_dd, c_dh, c_dl, c_dc;

  vsync_timing_gen i_vsync_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .vs_o(vs_o), .hs_o(hs_o),
    .de_o(de_o), .px_x(px_x), .px_y(px_y)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(addr);
    wr_data = 24'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic load(int vo, int vh, int vl, int hd, int hh, int hl, int hc,
                      int dd, int dh, int dl, int dc);
    c_vo = vo; c_vh = vh; c_vl = vl; c_hd = hd; c_hh = hh; c_hl = hl;
    c_hc = hc; c_dd = dd; c_dh = dh; c_dl = dl; c_dc = dc;
    wr(0, vo); wr(1, vh); wr(2, vl); wr(3, hd); wr(4, hh); wr(5, hl);
    wr(6, hc); wr(7, dd); wr(8, dh); wr(9, dl); wr(10, dc);
  endtask

  function automatic bit train_at(int p, int s, int hi, int lo, int cnt,
                                  output int x, output int y);
    int d, per, k;
    x = 0; y = 0;
    if (hi == 0 || cnt == 0 || p < s) return 1'b0;
    d = p - s;
    per = hi + lo;
    k = d / per;
    if (k < cnt && (d % per) < hi) begin
      x = d % per;
      y = k;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic idle_check(string tag);
    chk(tag, "vs idle", int'(vs_o), 0);
    chk(tag, "hs idle", int'(hs_o), 0);
    chk(tag, "de idle", int'(de_o), 0);
  endtask

  task automatic run(int ncyc, bit poke, string tv, string th, string td, string tp);
    int len, p, hx, hy, dx, dy;
    bit ev, eh, ed;
    len = c_vo + c_vh + c_vl;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      p  = (len == 0) ? 0 : k % len;
      ev = (p >= c_vo) && (p < c_vo + c_vh);
      eh = train_at(p, c_vo + c_hd, c_hh, c_hl, c_hc, hx, hy);
      ed = train_at(p, c_vo + c_dd, c_dh, c_dl, c_dc, dx, dy);
      chk(tv, $sformatf("vs at pos %0d", p), int'(vs_o), int'(ev));
      chk(th, $sformatf("hs at pos %0d", p), int'(hs_o), int'(eh));
      chk(td, $sformatf("de at pos %0d", p), int'(de_o), int'(ed));
      chk(tp, $sformatf("px_x at pos %0d", p), int'(px_x), dx);
      chk(tp, $sformatf("px_y at pos %0d", p), int'(px_y), dy);
      if (poke && (k % 37) == 3) begin
        wr_en   = 1'b1;
        wr_addr = 4'((k / 37) % 11);
        wr_data = 24'h00_0007;
      end
    end
    wr_en  = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    idle_check("R10");
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    idle_check("R1");
    chk("R1", "px_x reset", int'(px_x), 0);
    chk("R1", "px_y reset", int'(px_y), 0);
    rst_n = 1'b1;
    // R1: zero fields keep everything quiet while enabled
    c_vo = 0; c_vh = 0; c_vl = 0; c_hd = 0; c_hh = 0; c_hl = 0;
    c_hc = 0; c_dd = 0; c_dh = 0; c_dl = 0; c_dc = 0;
    run(20, 1'b0, "R1", "R1", "R1", "R1");
    // 16x8 active, 25 clocks per line, 13 lines, VS offset 5
    load(5, 50, 275, 0, 3, 22, 13, 107, 16, 9, 8);
    run(700, 1'b1, "R5", "R6", "R7", "R8");
    // R3: writes made while enabled must not have altered the frame
    run(340, 1'b0, "R3", "R3", "R3", "R3");
    // R4 wrap with zero offset; R6 count exhausted early; DE low 0 merges lines
    load(0, 25, 300, 0, 3, 22, 4, 107, 16, 0, 3);
    run(700, 1'b0, "R4", "R6", "R7", "R8");
    // R9: HS train cut at frame end, DE start beyond frame never fires
    load(2, 4, 10, 1, 2, 1, 100, 30, 4, 1, 2);
    run(60, 1'b0, "R2", "R9", "R9", "R9");
    // R10: restart from position 0 after a mid-frame disable
    run(23, 1'b0, "R10", "R10", "R10", "R10");
    run(40, 1'b0, "R10", "R10", "R10", "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule